// File: doc/BRIEF.md
# SD Host Register Access Shim

This block sits on the register path between a processor-side access port and the register file of an SD host controller. Every processor access enters on an upstream request port and leaves as zero, one or three accesses on a downstream valid/ready port. On the way, the block works around controller defects. A 16-bit write of the transfer-mode register is held back and joined to the next 16-bit command write as one 32-bit write. Two error-signal enable bits are dropped from 32-bit writes of the signal-enable register. Reads of the host version register return a fixed code. A write of the interrupt-enable register is followed by a read-modify-write of the block-gap control byte.

Each workaround has its own bit in the `FIX_EN` parameter: bit 0 joins the writes, bit 1 fixes the version, bit 2 drops the signal bits, bit 3 adds the block-gap update. A workaround whose bit is clear is not present, and accesses it would have handled pass through untouched. The upstream master holds its request until the single-cycle `up_ready` pulse. Data is right-aligned on both ports. `*_size` encodes 0 = byte, 1 = 16-bit, 2 = 32-bit, and addresses are byte offsets.

Top module: `sdh_access_shim`

## Requirements
- R1: After reset `dn_valid` and `up_ready` are low and the transfer-mode shadow holds 0, so a command write with no earlier transfer-mode write carries 0x0000 in bits 15:0.
- R2: With bit 0 of FIX_EN set, a 16-bit write at offset 0x0C makes no downstream access. It is acknowledged, and its low 16 data bits are kept in the shadow.
- R3: With bit 0 of FIX_EN set, a 16-bit write at offset 0x0E makes exactly one downstream 32-bit write at offset 0x0C. Bits 31:16 carry the command value and bits 15:0 carry the shadow.
- R4: The shadow keeps its value after a joined write, and only a new 16-bit write at 0x0C changes it.
- R5: Every access that no enabled workaround claims goes downstream once, with the same direction, size, address and data. A read returns the downstream read data.
- R6: With bit 2 of FIX_EN set, a 32-bit write at offset 0x38 is forwarded with bits 16 (data timeout) and 17 (CRC error) cleared. All other bits are unchanged.
- R7: With bit 1 of FIX_EN set, a 16-bit read at offset 0xFE returns 0x0001 without any downstream access.
- R8: With bit 3 of FIX_EN set, a 32-bit write at offset 0x34 is forwarded and then followed by a byte read and a byte write at offset 0x2A. The written byte equals the read byte with bit 3 set to bit 8 of the interrupt-enable value.
- R9: `up_ready` is a one-cycle pulse that comes only after every downstream access of that request has completed. Downstream command fields stay stable while `dn_valid` waits for `dn_ready`.
- R10: With FIX_EN = 0 every access, including those at 0x0C, 0x0E, 0x38, 0x34 and 0xFE, follows R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| up_valid | input | 1 | Upstream request, held until up_ready |
| up_we | input | 1 | 1 = write, 0 = read |
| up_size | input | 2 | 0 byte, 1 16-bit, 2 32-bit |
| up_addr | input | ADDR_W | Byte offset of the register |
| up_wdata | input | DATA_W | Write data, right-aligned |
| up_ready | output | 1 | One-cycle completion pulse |
| up_rdata | output | DATA_W | Read data, valid with up_ready |
| dn_valid | output | 1 | Downstream access request |
| dn_ready | input | 1 | Downstream access completes this cycle |
| dn_we | output | 1 | Downstream direction |
| dn_size | output | 2 | Downstream size, same encoding |
| dn_addr | output | ADDR_W | Downstream byte offset |
| dn_wdata | output | DATA_W | Downstream write data |
| dn_rdata | input | DATA_W | Downstream read data, valid with dn_ready |

## Verification
The bench builds two instances side by side. Instance u0 has every workaround enabled (FIX_EN = 4'b1111) and u1 has none (FIX_EN = 0), each in front of its own byte-array register model. With 8-bit offsets, every 16-bit register slot can be swept on both instances, and the special offsets can be compared directly between the two. The model's response latency rotates from 0 to 3 cycles per access. This exercises the stall paths, including the three-access sequence of the block-gap update under mixed latencies.

// File: rtl/sdh_shim_pkg.sv
package sdh_shim_pkg;

   // access size encoding shared by both ports
   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;
   localparam logic [1:0] SZ_WORD = 2'd2;

   // controller register offsets the workarounds decode
   localparam logic [7:0] OFS_XMODE = 8'h0C;
   localparam logic [7:0] OFS_CMD   = 8'h0E;
   localparam logic [7:0] OFS_GAP   = 8'h2A;
   localparam logic [7:0] OFS_IEN   = 8'h34;
   localparam logic [7:0] OFS_SIGEN = 8'h38;
   localparam logic [7:0] OFS_VER   = 8'hFE;

   // bit positions inside the FIX_EN parameter
   localparam int FIX_FUSE    = 0;
   localparam int FIX_VER     = 1;
   localparam int FIX_SIGMASK = 2;
   localparam int FIX_GAP     = 3;

   typedef enum logic [1:0] {
      ACT_FWD    = 2'd0,
      ACT_ABSORB = 2'd1,
      ACT_CONST  = 2'd2
   } act_e;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_MAIN   = 3'd1,
      ST_GAP_RD = 3'd2,
      ST_GAP_WR = 3'd3,
      ST_RESP   = 3'd4
   } seq_state_e;

endpackage

// File: rtl/sdh_shim_shadow.sv
module sdh_shim_shadow #(
   parameter int SH_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [SH_W-1:0] din,
   output logic [SH_W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (load) begin
         q <= din;
      end
   end

endmodule

// File: rtl/sdh_shim_xlate.sv
module sdh_shim_xlate
   import sdh_shim_pkg::*;
#(
   parameter int          ADDR_W        = 8,
   parameter int          DATA_W        = 32,
   parameter int          SH_W          = 16,
   parameter logic [3:0]  FIX_EN        = 4'b1111,
   parameter logic [31:0] SIG_DROP_MASK = 32'h0003_0000
) (
   input  logic              we,
   input  logic [1:0]        size,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [SH_W-1:0]   shadow,
   output act_e              act,
   output logic [1:0]        fwd_size,
   output logic [ADDR_W-1:0] fwd_addr,
   output logic [DATA_W-1:0] fwd_wdata,
   output logic              gap_follow,
   output logic              shadow_hit
);

   localparam logic [ADDR_W-1:0] A_XMODE = ADDR_W'(OFS_XMODE);
   localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(OFS_CMD);
   localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'(OFS_IEN);
   localparam logic [ADDR_W-1:0] A_SIGEN = ADDR_W'(OFS_SIGEN);
   localparam logic [ADDR_W-1:0] A_VER   = ADDR_W'(OFS_VER);
   localparam logic [DATA_W-1:0] DROP    = DATA_W'(SIG_DROP_MASK);

   logic half_wr, half_rd, word_wr;
   logic hit_absorb, hit_fuse, hit_ver, hit_sig, hit_ien;

   assign half_wr = we  && (size == SZ_HALF);
   assign half_rd = !we && (size == SZ_HALF);
   assign word_wr = we  && (size == SZ_WORD);

   generate
      if (FIX_EN[FIX_FUSE]) begin : g_fuse
         assign hit_absorb = half_wr && (addr == A_XMODE);
         assign hit_fuse   = half_wr && (addr == A_CMD);
      end else begin : g_no_fuse
         assign hit_absorb = 1'b0;
         assign hit_fuse   = 1'b0;
      end

      if (FIX_EN[FIX_VER]) begin : g_ver
         assign hit_ver = half_rd && (addr == A_VER);
      end else begin : g_no_ver
         assign hit_ver = 1'b0;
      end

      if (FIX_EN[FIX_SIGMASK]) begin : g_sig
         assign hit_sig = word_wr && (addr == A_SIGEN);
      end else begin : g_no_sig
         assign hit_sig = 1'b0;
      end

      if (FIX_EN[FIX_GAP]) begin : g_gap
         assign hit_ien = word_wr && (addr == A_IEN);
      end else begin : g_no_gap
         assign hit_ien = 1'b0;
      end
   endgenerate

   assign shadow_hit = hit_absorb;
   assign gap_follow = hit_ien;

   always_comb begin
      act       = ACT_FWD;
      fwd_size  = size;
      fwd_addr  = addr;
      fwd_wdata = wdata;
      if (hit_absorb) begin
         act = ACT_ABSORB;
      end else if (hit_ver) begin
         act = ACT_CONST;
      end else if (hit_fuse) begin
         fwd_size  = SZ_WORD;
         fwd_addr  = A_XMODE;
         fwd_wdata = DATA_W'({wdata[SH_W-1:0], shadow});
      end else if (hit_sig) begin
         fwd_wdata = wdata & ~DROP;
      end
   end

endmodule

// File: rtl/sdh_shim_seq.sv
module sdh_shim_seq
   import sdh_shim_pkg::*;
#(
   parameter int          ADDR_W      = 8,
   parameter int          DATA_W      = 32,
   parameter int          GAP_DET_BIT = 3,
   parameter logic [15:0] VER_CODE    = 16'h0001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              up_valid,
   input  logic              up_we,
   input  logic              card_in,
   input  act_e              act,
   input  logic [1:0]        fwd_size,
   input  logic [ADDR_W-1:0] fwd_addr,
   input  logic [DATA_W-1:0] fwd_wdata,
   input  logic              gap_follow,
   output logic              accept,
   output logic              up_ready,
   output logic [DATA_W-1:0] up_rdata,
   output logic              dn_valid,
   input  logic              dn_ready,
   output logic              dn_we,
   output logic [1:0]        dn_size,
   output logic [ADDR_W-1:0] dn_addr,
   output logic [DATA_W-1:0] dn_wdata,
   input  logic [DATA_W-1:0] dn_rdata
);

   localparam logic [ADDR_W-1:0] A_GAP = ADDR_W'(OFS_GAP);

   seq_state_e        state;
   logic              q_we;
   logic [1:0]        q_size;
   logic [ADDR_W-1:0] q_addr;
   logic [DATA_W-1:0] q_wdata;
   logic              q_gap;
   logic              q_card;
   logic [7:0]        gap_q;
   logic [DATA_W-1:0] rdata_q;
   logic              hs;
   logic [7:0]        gap_next;

   assign accept   = (state == ST_IDLE) && up_valid;
   assign hs       = dn_valid && dn_ready;
   assign up_ready = (state == ST_RESP);
   assign up_rdata = rdata_q;

   always_comb begin
      gap_next              = dn_rdata[7:0];
      gap_next[GAP_DET_BIT] = q_card;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         q_we    <= 1'b0;
         q_size  <= SZ_BYTE;
         q_addr  <= '0;
         q_wdata <= '0;
         q_gap   <= 1'b0;
         q_card  <= 1'b0;
         gap_q   <= '0;
         rdata_q <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (up_valid) begin
                  q_we    <= up_we;
                  q_size  <= fwd_size;
                  q_addr  <= fwd_addr;
                  q_wdata <= fwd_wdata;
                  q_gap   <= gap_follow;
                  q_card  <= card_in;
                  rdata_q <= (act == ACT_CONST) ? DATA_W'(VER_CODE) : '0;
                  state   <= (act == ACT_FWD) ? ST_MAIN : ST_RESP;
               end
            end
            ST_MAIN: begin
               if (hs) begin
                  rdata_q <= dn_rdata;
                  state   <= q_gap ? ST_GAP_RD : ST_RESP;
               end
            end
            ST_GAP_RD: begin
               if (hs) begin
                  gap_q <= gap_next;
                  state <= ST_GAP_WR;
               end
            end
            ST_GAP_WR: begin
               if (hs) begin
                  state <= ST_RESP;
               end
            end
            default: begin
               state <= ST_IDLE;
            end
         endcase
      end
   end

   always_comb begin
      dn_valid = 1'b0;
      dn_we    = q_we;
      dn_size  = q_size;
      dn_addr  = q_addr;
      dn_wdata = q_wdata;
      case (state)
         ST_MAIN: begin
            dn_valid = 1'b1;
         end
         ST_GAP_RD: begin
            dn_valid = 1'b1;
            dn_we    = 1'b0;
            dn_size  = SZ_BYTE;
            dn_addr  = A_GAP;
            dn_wdata = '0;
         end
         ST_GAP_WR: begin
            dn_valid = 1'b1;
            dn_we    = 1'b1;
            dn_size  = SZ_BYTE;
            dn_addr  = A_GAP;
            dn_wdata = DATA_W'(gap_q);
         end
         default: begin
            dn_valid = 1'b0;
         end
      endcase
   end

   // R9
   ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      up_ready |=> !up_ready);

   // R9
   dn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_we) && $stable(dn_size)
                                   && $stable(dn_addr) && $stable(dn_wdata)));

   // R9
   no_dn_while_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      up_ready |-> !dn_valid);

endmodule

// File: rtl/sdh_access_shim.sv
module sdh_access_shim
   import sdh_shim_pkg::*;
#(
   parameter int          ADDR_W        = 8,
   parameter int          DATA_W        = 32,
   parameter logic [3:0]  FIX_EN        = 4'b1111,
   parameter logic [15:0] VER_CODE      = 16'h0001,
   parameter logic [31:0] SIG_DROP_MASK = 32'h0003_0000,
   parameter int          CARD_IRQ_BIT  = 8,
   parameter int          GAP_DET_BIT   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              up_valid,
   input  logic              up_we,
   input  logic [1:0]        up_size,
   input  logic [ADDR_W-1:0] up_addr,
   input  logic [DATA_W-1:0] up_wdata,
   output logic              up_ready,
   output logic [DATA_W-1:0] up_rdata,
   output logic              dn_valid,
   input  logic              dn_ready,
   output logic              dn_we,
   output logic [1:0]        dn_size,
   output logic [ADDR_W-1:0] dn_addr,
   output logic [DATA_W-1:0] dn_wdata,
   input  logic [DATA_W-1:0] dn_rdata
);

   localparam int SH_W = DATA_W / 2;
   localparam logic [ADDR_W-1:0] A_XMODE = ADDR_W'(OFS_XMODE);
   localparam logic [ADDR_W-1:0] A_SIGEN = ADDR_W'(OFS_SIGEN);
   localparam logic [ADDR_W-1:0] A_VER   = ADDR_W'(OFS_VER);
   localparam logic [DATA_W-1:0] DROP    = DATA_W'(SIG_DROP_MASK);

   generate
      if (DATA_W != 32) begin : g_bad_data_w
         $error("sdh_access_shim: DATA_W must be 32 for the joined write layout");
      end
      if (ADDR_W < 8) begin : g_bad_addr_w
         $error("sdh_access_shim: ADDR_W must reach offset 0xFE");
      end
      if (GAP_DET_BIT > 7) begin : g_bad_gap_bit
         $error("sdh_access_shim: GAP_DET_BIT must lie in the control byte");
      end
      if (CARD_IRQ_BIT >= DATA_W) begin : g_bad_card_bit
         $error("sdh_access_shim: CARD_IRQ_BIT outside the data word");
      end
   endgenerate

   act_e              act;
   logic [1:0]        fwd_size;
   logic [ADDR_W-1:0] fwd_addr;
   logic [DATA_W-1:0] fwd_wdata;
   logic              gap_follow;
   logic              shadow_hit;
   logic              accept;
   logic [SH_W-1:0]   shadow_q;

   sdh_shim_shadow #(.SH_W(SH_W)) u_shadow (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept && shadow_hit),
      .din   (up_wdata[SH_W-1:0]),
      .q     (shadow_q)
   );

   sdh_shim_xlate #(
      .ADDR_W        (ADDR_W),
      .DATA_W        (DATA_W),
      .SH_W          (SH_W),
      .FIX_EN        (FIX_EN),
      .SIG_DROP_MASK (SIG_DROP_MASK)
   ) u_xlate (
      .we         (up_we),
      .size       (up_size),
      .addr       (up_addr),
      .wdata      (up_wdata),
      .shadow     (shadow_q),
      .act        (act),
      .fwd_size   (fwd_size),
      .fwd_addr   (fwd_addr),
      .fwd_wdata  (fwd_wdata),
      .gap_follow (gap_follow),
      .shadow_hit (shadow_hit)
   );

   sdh_shim_seq #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .GAP_DET_BIT (GAP_DET_BIT),
      .VER_CODE    (VER_CODE)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .up_valid   (up_valid),
      .up_we      (up_we),
      .card_in    (up_wdata[CARD_IRQ_BIT]),
      .act        (act),
      .fwd_size   (fwd_size),
      .fwd_addr   (fwd_addr),
      .fwd_wdata  (fwd_wdata),
      .gap_follow (gap_follow),
      .accept     (accept),
      .up_ready   (up_ready),
      .up_rdata   (up_rdata),
      .dn_valid   (dn_valid),
      .dn_ready   (dn_ready),
      .dn_we      (dn_we),
      .dn_size    (dn_size),
      .dn_addr    (dn_addr),
      .dn_wdata   (dn_wdata),
      .dn_rdata   (dn_rdata)
   );

   generate
      if (FIX_EN[FIX_FUSE]) begin : g_fuse_chk
         // R2
         xmode_half_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (dn_valid && dn_we) |-> !((dn_size == SZ_HALF) && (dn_addr == A_XMODE)));
      end
      if (FIX_EN[FIX_SIGMASK]) begin : g_sig_chk
         // R6
         sig_bits_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (dn_valid && dn_we && (dn_size == SZ_WORD) && (dn_addr == A_SIGEN))
               |-> ((dn_wdata & DROP) == '0));
      end
      if (FIX_EN[FIX_VER]) begin : g_ver_chk
         // R7
         ver_read_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
            dn_valid |-> !(!dn_we && (dn_size == SZ_HALF) && (dn_addr == A_VER)));
      end
   endgenerate

endmodule

// File: tb/sim_sdh_access_shim.sv
module sim_dn_model (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [1:0]  lat,
   input  logic        valid,
   output logic        ready,
   input  logic        we,
   input  logic [1:0]  size,
   input  logic [7:0]  addr,
   input  logic [31:0] wdata,
   output logic [31:0] rdata,
   output int          n_acc,
   output logic        last_we,
   output logic [1:0]  last_size,
   output logic [7:0]  last_addr,
   output logic [31:0] last_data
);
   logic [7:0] mem [256];
   logic [1:0] cnt;

   assign ready = valid && (cnt >= lat);

   always_comb begin
      rdata = '0;
      rdata[7:0] = mem[addr];
      if (size != 2'd0) rdata[15:8] = mem[8'(addr + 8'd1)];
      if (size == 2'd2) begin
         rdata[23:16] = mem[8'(addr + 8'd2)];
         rdata[31:24] = mem[8'(addr + 8'd3)];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         n_acc     <= 0;
         last_we   <= 1'b0;
         last_size <= '0;
         last_addr <= '0;
         last_data <= '0;
         for (int i = 0; i < 256; i++) mem[i] <= '0;
      end else begin
         if (valid && !ready) cnt <= cnt + 2'd1;
         else cnt <= '0;
         if (valid && ready) begin
            n_acc     <= n_acc + 1;
            last_we   <= we;
            last_size <= size;
            last_addr <= addr;
            last_data <= we ? wdata : rdata;
            if (we) begin
               mem[addr] <= wdata[7:0];
               if (size != 2'd0) mem[8'(addr + 8'd1)] <= wdata[15:8];
               if (size == 2'd2) begin
                  mem[8'(addr + 8'd2)] <= wdata[23:16];
                  mem[8'(addr + 8'd3)] <= wdata[31:24];
               end
            end
         end
      end
   end
endmodule

module sim_sdh_access_shim;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic        t_we;
   logic [1:0]  t_size;
   logic [7:0]  t_addr;
   logic [31:0] t_wdata;
   logic        v0, v1, r0, r1;
   logic [31:0] rd0, rd1;
   logic [1:0]  lat0, lat1;
   logic        d0_valid, d0_ready, d0_we, d1_valid, d1_ready, d1_we;
   logic [1:0]  d0_size, d1_size;
   logic [7:0]  d0_addr, d1_addr;
   logic [31:0] d0_wdata, d0_rdata, d1_wdata, d1_rdata;
   int          m0_n, m1_n;
   logic        m0_we, m1_we;
   logic [1:0]  m0_size, m1_size;
   logic [7:0]  m0_addr, m1_addr;
   logic [31:0] m0_data, m1_data;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int lat_rot = 0;

   sdh_access_shim #(.FIX_EN(4'b1111)) u0 (
      .clk(clk), .rst_n(rst_n), .up_valid(v0), .up_we(t_we), .up_size(t_size),
      .up_addr(t_addr), .up_wdata(t_wdata), .up_ready(r0), .up_rdata(rd0),
      .dn_valid(d0_valid), .dn_ready(d0_ready), .dn_we(d0_we), .dn_size(d0_size),
      .dn_addr(d0_addr), .dn_wdata(d0_wdata), .dn_rdata(d0_rdata));

   sdh_access_shim #(.FIX_EN(4'b0000)) u1 (
      .clk(clk), .rst_n(rst_n), .up_valid(v1), .up_we(t_we), .up_size(t_size),
      .up_addr(t_addr), .up_wdata(t_wdata), .up_ready(r1), .up_rdata(rd1),
      .dn_valid(d1_valid), .dn_ready(d1_ready), .dn_we(d1_we), .dn_size(d1_size),
      .dn_addr(d1_addr), .dn_wdata(d1_wdata), .dn_rdata(d1_rdata));

   sim_dn_model u_m0 (
      .clk(clk), .rst_n(rst_n), .lat(lat0), .valid(d0_valid), .ready(d0_ready),
      .we(d0_we), .size(d0_size), .addr(d0_addr), .wdata(d0_wdata), .rdata(d0_rdata),
      .n_acc(m0_n), .last_we(m0_we), .last_size(m0_size), .last_addr(m0_addr),
      .last_data(m0_data));

   sim_dn_model u_m1 (
      .clk(clk), .rst_n(rst_n), .lat(lat1), .valid(d1_valid), .ready(d1_ready),
      .we(d1_we), .size(d1_size), .addr(d1_addr), .wdata(d1_wdata), .rdata(d1_rdata),
      .n_acc(m1_n), .last_we(m1_we), .last_size(m1_size), .last_addr(m1_addr),
      .last_data(m1_data));

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_chk  = n_chk + 1;
         n_fail = n_fail + 1;
         $display("FAIL watchdog: run hung, actual cycles %0d expected below 150000", cyc);
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk = n_chk + 1;
      if (act !== exp) begin
         n_fail = n_fail + 1;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic acc(input int sel, input logic we, input logic [1:0] sz,
                      input logic [7:0] a, input logic [31:0] d,
                      output logic [31:0] rd, output int dn);
      int n0;
      n0 = (sel == 0) ? m0_n : m1_n;
      @(negedge clk);
      lat0 = 2'(lat_rot);
      lat1 = 2'(lat_rot);
      lat_rot = (lat_rot + 1) % 4;
      t_we = we; t_size = sz; t_addr = a; t_wdata = d;
      if (sel == 0) v0 = 1'b1; else v1 = 1'b1;
      forever begin
         @(negedge clk);
         if ((sel == 0 && r0) || (sel == 1 && r1)) break;
      end
      rd = (sel == 0) ? rd0 : rd1;
      v0 = 1'b0; v1 = 1'b0;
      dn = ((sel == 0) ? m0_n : m1_n) - n0;
   endtask

   initial begin
      logic [31:0] rd;
      int dn;
      logic [15:0] sh;
      v0 = 0; v1 = 0; t_we = 0; t_size = 0; t_addr = 0; t_wdata = 0; lat0 = 0; lat1 = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 dn_valid u0", 32'(d0_valid), 0);
      chk("R1 up_ready u0", 32'(r0), 0);
      chk("R1 dn_valid u1", 32'(d1_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 + R3: command with shadow at reset value
      acc(0, 1, 2'd1, 8'h0E, 32'h0000_ABCD, rd, dn);
      chk("R1 R3 one dn access", 32'(dn), 1);
      chk("R3 joined size", 32'(m0_size), 2);
      chk("R3 joined addr", 32'(m0_addr), 32'h0C);
      chk("R1 joined data low zero", m0_data, 32'hABCD_0000);
      // R2 absorbed transfer-mode write
      acc(0, 1, 2'd1, 8'h0C, 32'h0000_1234, rd, dn);
      chk("R2 no dn access", 32'(dn), 0);
      acc(0, 0, 2'd2, 8'h0C, 0, rd, dn);
      chk("R2 register untouched", rd, 32'hABCD_0000);
      // R3/R4 sweep of mode/command pairs
      sh = 16'h1234;
      for (int i = 0; i < 8; i++) begin
         logic [15:0] cmdv;
         cmdv = 16'(i * 16'h1111 + 16'h0F0F);
         if (i % 2 == 0) begin
            sh = 16'(i * 16'h2357 + 16'h0101);
            acc(0, 1, 2'd1, 8'h0C, 32'(sh), rd, dn);
            chk("R2 absorbed in sweep", 32'(dn), 0);
         end
         acc(0, 1, 2'd1, 8'h0E, 32'(cmdv), rd, dn);
         chk("R3 single access", 32'(dn), 1);
         chk("R4 R3 joined data", m0_data, {cmdv, sh});
         acc(0, 0, 2'd2, 8'h0C, 0, rd, dn);
         chk("R3 readback", rd, {cmdv, sh});
      end
      // R5 half sweep on u0 outside the claimed offsets
      for (int a = 0; a < 256; a += 2) begin
         logic [15:0] f;
         if (a == 8'h0C || a == 8'h0E || a == 8'hFE) continue;
         f = 16'(a * 16'h0101) ^ 16'h5A3C;
         acc(0, 1, 2'd1, 8'(a), 32'(f), rd, dn);
         chk("R5 fwd write count", 32'(dn), 1);
         chk("R5 fwd write fields", {m0_we, 5'd0, m0_size, m0_addr, m0_data[15:0]},
             {1'b1, 5'd0, 2'd1, 8'(a), f});
         acc(0, 0, 2'd1, 8'(a), 0, rd, dn);
         chk("R5 fwd read", rd, 32'(f));
      end
      // R6 / R10 signal-enable word writes
      for (int i = 0; i < 16; i++) begin
         logic [31:0] p;
         p = (i == 0) ? 32'hFFFF_FFFF : 32'(i) * 32'h1357_9BDF;
         acc(0, 1, 2'd2, 8'h38, p, rd, dn);
         acc(0, 0, 2'd2, 8'h38, 0, rd, dn);
         chk("R6 bits 16,17 dropped", rd, p & 32'hFFFC_FFFF);
         acc(1, 1, 2'd2, 8'h38, p, rd, dn);
         acc(1, 0, 2'd2, 8'h38, 0, rd, dn);
         chk("R10 signal enable unchanged", rd, p);
      end
      // R7 / R10 version register
      acc(0, 1, 2'd1, 8'hFE, 32'h0000_BEEF, rd, dn);
      acc(0, 0, 2'd1, 8'hFE, 0, rd, dn);
      chk("R7 forced version", rd, 32'h0000_0001);
      chk("R7 no dn access", 32'(dn), 0);
      acc(0, 0, 2'd0, 8'hFE, 0, rd, dn);
      chk("R5 byte read of version slot", rd, 32'h0000_00EF);
      acc(1, 1, 2'd1, 8'hFE, 32'h0000_BEEF, rd, dn);
      acc(1, 0, 2'd1, 8'hFE, 0, rd, dn);
      chk("R10 version passes", rd, 32'h0000_BEEF);
      chk("R10 version dn access", 32'(dn), 1);
      // R8 / R9 / R10 block-gap update
      for (int i = 0; i < 8; i++) begin
         logic [7:0] pre;
         logic card;
         logic [31:0] v;
         pre  = (i / 2 == 0) ? 8'h00 : (i / 2 == 1) ? 8'hFF : (i / 2 == 2) ? 8'hA5 : 8'h5A;
         card = 1'(i % 2);
         v    = 32'h1234_00F0 | (32'(card) << 8);
         acc(0, 1, 2'd0, 8'h2A, 32'(pre), rd, dn);
         acc(0, 1, 2'd2, 8'h34, v, rd, dn);
         chk("R8 R9 three accesses done at ack", 32'(dn), 3);
         chk("R8 last is byte write at gap", {m0_we, 5'd0, m0_size, m0_addr},
             {1'b1, 5'd0, 2'd0, 8'h2A});
         acc(0, 0, 2'd0, 8'h2A, 0, rd, dn);
         chk("R8 gap byte", rd, 32'((pre & 8'hF7) | (8'(card) << 3)));
         acc(0, 0, 2'd2, 8'h34, 0, rd, dn);
         chk("R8 ien forwarded", rd, v);
         acc(1, 1, 2'd0, 8'h2A, 32'(pre), rd, dn);
         acc(1, 1, 2'd2, 8'h34, v, rd, dn);
         chk("R10 single access", 32'(dn), 1);
         acc(1, 0, 2'd0, 8'h2A, 0, rd, dn);
         chk("R10 gap untouched", rd, 32'(pre));
      end
      // R10 transfer-mode and command on u1
      acc(1, 1, 2'd1, 8'h0C, 32'h0000_7777, rd, dn);
      chk("R10 mode write forwarded", 32'(dn), 1);
      acc(1, 1, 2'd1, 8'h0E, 32'h0000_3C3C, rd, dn);
      chk("R10 cmd as half", {m1_size, m1_addr}, {2'd1, 8'h0E});
      acc(1, 0, 2'd2, 8'h0C, 0, rd, dn);
      chk("R10 mode and cmd", rd, 32'h3C3C_7777);
      // R5 / R10 full half sweep on u1
      for (int a = 0; a < 256; a += 2) begin
         logic [15:0] f;
         f = 16'(a * 16'h0203) ^ 16'hC3A5;
         acc(1, 1, 2'd1, 8'(a), 32'(f), rd, dn);
         acc(1, 0, 2'd1, 8'(a), 0, rd, dn);
         chk("R10 half sweep", rd, 32'(f));
      end
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule